// File: doc/BRIEF.md
# EEPROM Byte Write and Completion Poll Controller

This block sits on the host side of a byte-wide EEPROM. It takes one command at a time on a valid/ready handshake. A command is either a byte write or a single-byte read. The block then produces the chip-enable, output-enable and write-enable strobes and drives or samples the shared data bus. Each strobe pulse lasts a number of clock cycles set by a parameter.

After the write strobe, the block waits for the device to finish its internal programming. A static configuration input selects one of two ways to detect this. In the first, the block reads the written location again and again; while programming is still running, the device returns the inverted bit 7. In the second, the block watches the device's active-low busy line. A poll budget limits the wait. The requester sees a one-cycle done pulse, an error flag and, for reads, the byte that was read.

Top module: `eeprom_wr_ctrl`

## Requirements
- R1: After reset, req_ready is 1, all three strobes are high (1), the data driver is disabled, and done is 0.
- R2: For a write, mem_ce_n and mem_we_n go low together for exactly WE_CYC cycles. mem_oe_n stays high throughout, and the data driver is enabled with the command byte on mem_dq_out.
- R3: For a read, mem_ce_n and mem_oe_n go low for exactly RD_CYC cycles with mem_we_n high. The byte on mem_dq_in in the last low cycle is returned on rd_data. done rises RD_CYC+1 cycles after the edge that accepts the request.
- R4: The data driver is disabled in every cycle in which mem_oe_n is low, and also in the cycle just before mem_oe_n falls.
- R5: When cfg_rdybusy is 0 (polling mode), a write is followed by one or more reads of the same address. Completion is the first read whose bit 7 equals bit 7 of the written byte, and done_error is then 0.
- R6: When cfg_rdybusy is 1 (busy-line mode), a write issues no reads. The block waits BUSY_SETTLE cycles, then completes when mem_busy_n is sampled high, with done_error 0.
- R7: If MAX_POLLS poll reads, or MAX_POLLS busy-line samples, pass without completion, done is raised with done_error 1.
- R8: done is high for one cycle only. Once a request is accepted, req_ready stays 0 until done has been given. Requests offered in that interval are ignored and have no effect on the device contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Controller idle, command taken when valid |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Byte to write |
| cfg_rdybusy | input | 1 | Completion source: 0 = bit 7 polling, 1 = busy line |
| done | output | 1 | One-cycle completion pulse |
| done_error | output | 1 | Poll budget exhausted, valid with done |
| rd_data | output | 8 | Byte read, valid with done for reads |
| mem_addr | output | ADDR_W | Device address |
| mem_dq_out | output | 8 | Data driven toward device |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 8 | Data bus as seen from device |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_busy_n | input | 1 | Device busy, active low, synchronous to clk |

## Verification
A read completes at a fixed time: done appears RD_CYC+1 cycles after the accepting edge. The bench records the accepting cycle for each read and compares it with the cycle in which done is seen. A write completes at a time set by the device model's programming time. For writes, the bench therefore checks only the order of results: each result popped from its queue is compared with the expected item, whenever done appears. Strobe widths are measured at the falling edge that follows each pulse end. This makes every width check independent of the time the device needs.

// File: rtl/eewr_pkg.sv
// Package: state encoding shared by the EEPROM write controller.
// Assumes: one command in flight at a time.
package eewr_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_TURN,
        ST_RPULSE,
        ST_PEVAL,
        ST_BSETTLE,
        ST_BWAIT,
        ST_DONE
    } eewr_state_t;
endpackage

// File: rtl/eewr_timer.sv
// Down-counter that times one strobe phase.
// Assumes: load has priority over counting; zero is high once the loaded count has run out.
module eewr_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // Load a new phase length, or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/eewr_judge.sv
// Completion judge: decides, at each evaluation step, whether the write is done or the budget is spent.
// Assumes: eval is high for one cycle per poll read or busy-line sample; clear comes before the first eval.
module eewr_judge #(
    parameter int MAX_POLLS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic eval,
    input  logic use_busy,
    input  logic rd_bit7,
    input  logic wr_bit7,
    input  logic busy_n,
    output logic finished,
    output logic timed_out
);
    localparam int CW = $clog2(MAX_POLLS + 1);

    logic [CW-1:0] tries_q;
    logic          ok;
    logic          last;

    assign ok        = use_busy ? busy_n : (rd_bit7 == wr_bit7);
    assign last      = (tries_q == CW'(MAX_POLLS - 1));
    assign finished  = eval && (ok || last);
    assign timed_out = eval && !ok && last;

    // Count the evaluations that did not finish the write.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)       tries_q <= '0;
        else if (eval && !finished) tries_q <= tries_q + 1'b1;
    end

    AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tries_q < CW'(MAX_POLLS)); // R7
endmodule

// File: rtl/eeprom_wr_ctrl.sv
// Host-side EEPROM byte write and read controller.
// After each write it checks for completion, by reading bit 7 back or by watching the busy line.
// Assumes: mem_busy_n is synchronous to clk; cfg_rdybusy changes only while idle;
// WE_CYC, RD_CYC and BUSY_SETTLE are at least 1.
module eeprom_wr_ctrl
    import eewr_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int WE_CYC      = 5,
    parameter int RD_CYC      = 3,
    parameter int BUSY_SETTLE = 4,
    parameter int MAX_POLLS   = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    input  logic              cfg_rdybusy,
    output logic              done,
    output logic              done_error,
    output logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [7:0]        mem_dq_in,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    input  logic              mem_busy_n
);
    localparam int TMAX_A = (WE_CYC > RD_CYC) ? WE_CYC : RD_CYC;
    localparam int TMAX   = (TMAX_A > BUSY_SETTLE) ? TMAX_A : BUSY_SETTLE;
    localparam int TW     = $clog2(TMAX + 1);
    localparam logic [TW-1:0] WE_LD  = TW'(WE_CYC - 1);
    localparam logic [TW-1:0] RD_LD  = TW'(RD_CYC - 1);
    localparam logic [TW-1:0] SET_LD = TW'(BUSY_SETTLE - 1);

    eewr_state_t       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        wdata_q;
    logic [7:0]        rd_q;
    logic              is_wr_q;
    logic              err_q;
    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_zero;
    logic              jg_clear;
    logic              jg_eval;
    logic              jg_fin;
    logic              jg_tout;

    eewr_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    assign jg_eval = (state_q == ST_PEVAL) || (state_q == ST_BWAIT);

    eewr_judge #(.MAX_POLLS(MAX_POLLS)) u_judge (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (jg_clear),
        .eval      (jg_eval),
        .use_busy  (cfg_rdybusy),
        .rd_bit7   (rd_q[7]),
        .wr_bit7   (wdata_q[7]),
        .busy_n    (mem_busy_n),
        .finished  (jg_fin),
        .timed_out (jg_tout)
    );

    // Next-state decode, plus timer loads and the judge clear.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        jg_clear = 1'b0;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = req_write ? ST_WSETUP : ST_TURN;
            ST_WSETUP:  begin tmr_load = 1'b1; tmr_val = WE_LD; state_d = ST_WPULSE; end
            ST_WPULSE:  if (tmr_zero) state_d = ST_WHOLD;
            ST_WHOLD: begin
                jg_clear = 1'b1;
                if (cfg_rdybusy) begin
                    tmr_load = 1'b1; tmr_val = SET_LD; state_d = ST_BSETTLE;
                end else begin
                    state_d = ST_TURN;
                end
            end
            ST_TURN:    begin tmr_load = 1'b1; tmr_val = RD_LD; state_d = ST_RPULSE; end
            ST_RPULSE:  if (tmr_zero) state_d = is_wr_q ? ST_PEVAL : ST_DONE;
            ST_PEVAL: begin
                if (jg_fin) state_d = ST_DONE;
                else begin tmr_load = 1'b1; tmr_val = RD_LD; state_d = ST_RPULSE; end
            end
            ST_BSETTLE: if (tmr_zero) state_d = ST_BWAIT;
            ST_BWAIT:   if (jg_fin) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Latch the command when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            is_wr_q <= 1'b0;
        end else if (state_q == ST_IDLE && req_valid) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            is_wr_q <= req_write;
        end
    end

    // Capture the bus in the last cycle of each read pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                                rd_q <= '0;
        else if (state_q == ST_RPULSE && tmr_zero) rd_q <= mem_dq_in;
    end

    // Record the error status when the controller enters the done state.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          err_q <= 1'b0;
        else if (state_d == ST_DONE && state_q != ST_DONE) err_q <= jg_tout;
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign done       = (state_q == ST_DONE);
    assign done_error = done && err_q;
    assign rd_data    = rd_q;
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign mem_dq_oe  = (state_q == ST_WSETUP) || (state_q == ST_WPULSE) || (state_q == ST_WHOLD);
    assign mem_ce_n   = !((state_q == ST_WPULSE) || (state_q == ST_RPULSE));
    assign mem_we_n   = (state_q != ST_WPULSE);
    assign mem_oe_n   = (state_q != ST_RPULSE);

    // Checker logic: count the cycles in which write enable is low.
    logic [TW:0] we_lo_q;
    always_ff @(posedge clk) begin
        if (!rst_n || mem_we_n) we_lo_q <= '0;
        else                    we_lo_q <= we_lo_q + 1'b1;
    end

    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n)); // R2
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_lo_q == (TW+1)'(WE_CYC))); // R2
    AST_BUS_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe)); // R4
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe); // R4
    AST_BUSY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdybusy && $fell(mem_oe_n)) |-> !is_wr_q); // R6
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_error |-> done); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(mem_addr)); // R2
endmodule

// File: tb/test_eeprom_wr_ctrl.sv
// Scoreboard bench: the driver queues expected results, the monitor pops them on each done.
module test_eeprom_wr_ctrl;
    localparam int AW      = 8;
    localparam int WE_C    = 4;
    localparam int RD_C    = 2;
    localparam int SETTLE  = 3;
    localparam int POLLS   = 24;
    localparam int WRITE_T = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_wdata = '0;
    logic          cfg_rdybusy = 1'b0;
    logic          done, done_error;
    logic [7:0]    rd_data;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_dq_out;
    logic          mem_dq_oe;
    logic [7:0]    mem_dq_in;
    logic          mem_ce_n, mem_oe_n, mem_we_n;
    logic          mem_busy_n;

    always #10 clk = ~clk;

    eeprom_wr_ctrl #(.ADDR_W(AW), .WE_CYC(WE_C), .RD_CYC(RD_C),
                     .BUSY_SETTLE(SETTLE), .MAX_POLLS(POLLS)) i_eeprom_wr_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_rdybusy(cfg_rdybusy), .done(done), .done_error(done_error),
        .rd_data(rd_data), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_busy_n(mem_busy_n)
    );

    // ---------------- device model ----------------
    logic [7:0]    mem [256];
    logic [AW-1:0] last_a;
    logic [7:0]    last_d;
    logic [7:0]    lat_d;
    logic [AW-1:0] lat_a;
    logic          prev_we;
    int            busy_cnt;
    logic          stuck = 1'b0;
    logic          dev_busy;

    assign dev_busy   = (busy_cnt != 0) || stuck;
    assign mem_busy_n = !dev_busy;
    assign mem_dq_in  = (!mem_ce_n && !mem_oe_n) ?
        ((dev_busy && mem_addr == last_a) ? {~last_d[7], last_d[6:0] ^ 7'h55} : mem[mem_addr])
        : 8'hFF;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    end

    always @(posedge clk) begin
        prev_we <= mem_we_n;
        if (!mem_we_n && !mem_ce_n && mem_dq_oe) begin
            lat_d <= mem_dq_out;
            lat_a <= mem_addr;
        end
        if (!rst_n) busy_cnt <= 0;
        else if (mem_we_n && !prev_we) begin
            mem[lat_a] <= lat_d;
            last_a     <= lat_a;
            last_d     <= lat_d;
            busy_cnt   <= WRITE_T;
        end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic       is_rd;
        logic       busy_mode;
        logic       exp_err;
        logic [7:0] exp_data;
        int         acc;
        string      req;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_fail = 0;
    int    cyc = 0;
    logic [7:0] shadow [256];

    initial begin
        for (int i = 0; i < 256; i++) shadow[i] = 8'h00;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 60000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
            summary();
            $finish;
        end
    end

    // Monitor: strobe widths, bus turnaround, reads per write, result comparison.
    int   we_w = 0, oe_w = 0, oe_pulses = 0;
    logic prev_oe_dq = 1'b0, turn_bad = 1'b0, prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n) we_w++;
            else if (we_w != 0) begin
                check(we_w == WE_C, "R2 write pulse width", we_w, WE_C);
                we_w = 0;
            end
            if (!mem_oe_n) begin
                if (mem_dq_oe || (oe_w == 0 && prev_oe_dq)) turn_bad = 1'b1;
                oe_w++;
            end else if (oe_w != 0) begin
                check(oe_w == RD_C, "R3 read pulse width", oe_w, RD_C);
                check(!turn_bad, "R4 bus released around read", turn_bad, 0);
                turn_bad = 1'b0;
                oe_w = 0;
                oe_pulses++;
            end
            if (done) begin
                check(!prev_done, "R8 done single cycle", prev_done, 0);
                if (q.size() == 0) check(1'b0, "R8 unexpected done", 1, 0);
                else begin
                    item_t it;
                    it = q.pop_front();
                    check(done_error == it.exp_err, it.req, done_error, it.exp_err);
                    if (it.is_rd) begin
                        check(rd_data == it.exp_data, {it.req, " data"}, rd_data, it.exp_data);
                        check(cyc - it.acc == RD_C + 1, "R3 read latency", cyc - it.acc, RD_C + 1);
                    end else if (it.busy_mode) begin
                        check(oe_pulses == 0, "R6 no read in busy mode", oe_pulses, 0);
                    end else if (!it.exp_err) begin
                        check(oe_pulses >= 1, "R5 poll reads issued", oe_pulses, 1);
                    end else begin
                        check(oe_pulses == POLLS, "R7 poll budget", oe_pulses, POLLS);
                    end
                end
                oe_pulses = 0;
            end
            prev_done  = done;
            prev_oe_dq = mem_dq_oe;
        end
    end

    // Driver: offer one command and queue its expected result.
    task automatic do_cmd(input logic wr, input logic [AW-1:0] a, input logic [7:0] d,
                          input logic exp_err, input string req);
        item_t it;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        it.is_rd = !wr; it.busy_mode = cfg_rdybusy; it.exp_err = exp_err;
        it.exp_data = shadow[a]; it.acc = cyc; it.req = req;
        if (wr) shadow[a] = d;
        q.push_back(it);
    endtask

    task automatic drain();
        while (q.size() != 0 || !req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        check({mem_ce_n, mem_oe_n, mem_we_n} == 3'b111, "R1 strobes high", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
        check(mem_dq_oe == 1'b0, "R1 driver off", mem_dq_oe, 0);
        check(done == 1'b0, "R1 done low", done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Polling mode
        do_cmd(1'b1, 8'h10, 8'hA5, 1'b0, "R5 write bit7=1");
        do_cmd(1'b1, 8'h11, 8'h3C, 1'b0, "R5 write bit7=0");
        do_cmd(1'b0, 8'h10, 8'h00, 1'b0, "R3 read 10");
        do_cmd(1'b0, 8'h11, 8'h00, 1'b0, "R3 read 11");
        do_cmd(1'b0, 8'h20, 8'h00, 1'b0, "R3 read untouched");
        do_cmd(1'b1, 8'h12, 8'h81, 1'b0, "R5 write 12");
        // Offer a request while busy: it must be ignored (R8)
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h13; req_wdata = 8'hEE;
        for (int k = 0; k < 3; k++) begin
            check(req_ready == 1'b0, "R8 ready low while busy", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        do_cmd(1'b0, 8'h13, 8'h00, 1'b0, "R8 ignored write left 13 unchanged");
        drain();
        stuck = 1'b1;
        do_cmd(1'b1, 8'h14, 8'h55, 1'b1, "R7 poll timeout");
        drain();
        stuck = 1'b0;
        do_cmd(1'b0, 8'h14, 8'h00, 1'b0, "R3 read after timeout");
        drain();

        // Busy-line mode
        cfg_rdybusy = 1'b1;
        do_cmd(1'b1, 8'h30, 8'hF0, 1'b0, "R6 busy write");
        do_cmd(1'b0, 8'h30, 8'h00, 1'b0, "R6 read back");
        do_cmd(1'b1, 8'h31, 8'h0F, 1'b0, "R6 busy write 2");
        drain();
        stuck = 1'b1;
        do_cmd(1'b1, 8'h32, 8'h77, 1'b1, "R7 busy timeout");
        drain();
        stuck = 1'b0;
        do_cmd(1'b0, 8'h31, 8'h00, 1'b0, "R6 read 31");
        drain();
        repeat (5) @(negedge clk);
        check(q.size() == 0, "R8 all results returned", q.size(), 0);
        summary();
        $finish;
    end
endmodule